// File: doc/BRIEF.md
# Fermat Modular Inversion Sequencer

This block computes the modular inverse of an operand that is already in Montgomery form, modulo a prime chosen at run time. It raises the operand to the power p-2, which by Fermat's little theorem equals the inverse. Every squaring and every multiplication in that exponentiation goes to one bit-serial Montgomery multiplier. There is no other arithmetic unit and no dedicated inversion datapath.

The caller presents the operand, the odd prime modulus and the Montgomery image of one (2^W mod p). It then pulses `start` for one cycle. The sequencer forms the exponent p-2 from the modulus and finds its highest set bit. It walks the exponent from that bit down to bit 0 using the left-to-right binary method: a square on every bit, and an extra multiply by the operand when the bit is 1. At the end it pulses `done` with the inverse in Montgomery form on `inv_mont`.

The result is exact, but the block is slow: a W-bit modulus needs up to about 2W multiplications of W+3 cycles each. A zero operand gives an undefined result.

Top module: `fermat_inverter`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy` and `done` are 0 and `inv_mont` is 0.
- R2: For an odd prime p < 2^W, a nonzero x < p, `x_mont` = x·2^W mod p and `mont_one` = 2^W mod p, the value on `inv_mont` at `done` is x^(-1)·2^W mod p. This value is below p, and its product with x is 1 mod p.
- R3: The exponent is formed from the `modulus` input sampled on the start cycle, so different moduli on successive runs give correct inverses without any configuration.
- R4: Let L be the bit length of p-2 and C the number of 1 bits in p-2. `done` is seen exactly (L + C)·(W+3) clock edges after the edge that accepts `start`.
- R5: A `start` pulse, with any operand values, that arrives while `busy` is 1 is ignored. The running inversion returns the same result with the same latency.
- R6: `done` is high for exactly one cycle, and `inv_mont` keeps its value until the next completion.
- R7: Zero bits of p-2 above its highest set bit are skipped, so small moduli such as 3 and 5 (exponents 1 and 3) invert correctly at the shorter latency that R4 gives.
- R8: `busy` is 1 from the cycle after an accepted `start` until the cycle in which `done` is 1. In that cycle `busy` is 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request, accepted only when idle |
| x_mont | input | W | Operand in Montgomery form, below the modulus |
| modulus | input | W | Odd prime modulus, at least 3 |
| mont_one | input | W | Montgomery image of one, 2^W mod modulus |
| busy | output | 1 | Inversion in progress |
| done | output | 1 | One-cycle completion pulse |
| inv_mont | output | W | Inverse in Montgomery form, held between runs |

## Verification
The assertions check some properties on every cycle. Each multiplier result is fully reduced below the modulus. `done` is a single-cycle pulse that never coincides with `busy`. An accepted start raises `busy`. The result register changes only when `done` is raised. Whether the result is the correct inverse, whether the latency matches the exponent's length and weight, and whether a start pulse during a run is ignored can be shown only by the bench. It runs directed moduli, including the shortest primes and the largest 16-bit prime, and random operands, and compares the results against an extended-Euclid model.

// File: rtl/inv_seq_pkg.sv
package inv_seq_pkg;

    localparam int unsigned MAXW = 64;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE_SQ,
        ST_WAIT_SQ,
        ST_ISSUE_MU,
        ST_WAIT_MU
    } seq_state_e;

    // Index of the highest set bit; 0 for an all-zero value.
    function automatic int unsigned top_bit(input logic [MAXW-1:0] v);
        int unsigned pos;
        pos = 0;
        for (int unsigned i = 0; i < MAXW; i++) begin
            if (v[i]) pos = i;
        end
        return pos;
    endfunction

endpackage

// File: rtl/fi_mont_mul.sv
module fi_mont_mul #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] p,
    output logic         done,
    output logic [W-1:0] res
);
    localparam int unsigned CW = $clog2(W + 1);
    localparam int unsigned AW = W + 2;

    logic          run;
    logic [CW-1:0] cnt;
    logic [AW-1:0] acc, s1, s2, nxt, red;
    logic [W-1:0]  a_sh, b_r, p_r;

    always_comb begin
        s1  = acc + (a_sh[0] ? {2'b00, b_r} : '0);
        s2  = s1[0] ? s1 + {2'b00, p_r} : s1;
        nxt = s2 >> 1;
        red = (acc >= {2'b00, p_r}) ? acc - {2'b00, p_r} : acc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            acc  <= '0;
            a_sh <= '0;
            b_r  <= '0;
            p_r  <= '0;
            res  <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                a_sh <= a;
                b_r  <= b;
                p_r  <= p;
                acc  <= '0;
                cnt  <= '0;
                run  <= 1'b1;
            end else if (run) begin
                if (cnt == CW'(W)) begin
                    res  <= red[W-1:0];
                    done <= 1'b1;
                    run  <= 1'b0;
                end else begin
                    acc  <= nxt;
                    a_sh <= a_sh >> 1;
                    cnt  <= cnt + 1'b1;
                end
            end
        end
    end

    AST_MUL_REDUCED: assert property (@(posedge clk) disable iff (rst)
        done |-> (res < p_r)); // R2

endmodule

// File: rtl/fi_exp_scan.sv
module fi_exp_scan
    import inv_seq_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] modulus,
    input  logic         step,
    output logic         cur_bit,
    output logic         at_lsb
);
    localparam int unsigned IW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  expo;
    logic [W-1:0]  expo_new;
    logic [IW-1:0] idx;

    assign expo_new = modulus - W'(2);

    always_ff @(posedge clk) begin
        if (rst) begin
            expo <= '0;
            idx  <= '0;
        end else if (load) begin
            expo <= expo_new;
            idx  <= IW'(top_bit(MAXW'(expo_new)));
        end else if (step) begin
            idx  <= idx - 1'b1;
        end
    end

    assign cur_bit = expo[idx];
    assign at_lsb  = (idx == '0);

    AST_STEP_ABOVE_LSB: assert property (@(posedge clk) disable iff (rst)
        step |-> !at_lsb); // R7

endmodule

// File: rtl/fi_seq_ctrl.sv
module fi_seq_ctrl
    import inv_seq_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] x_mont,
    input  logic [W-1:0] modulus,
    input  logic [W-1:0] mont_one,
    input  logic         mul_done,
    input  logic [W-1:0] mul_res,
    input  logic         cur_bit,
    input  logic         at_lsb,
    output logic         load,
    output logic         step,
    output logic         mul_start,
    output logic [W-1:0] mul_a,
    output logic [W-1:0] mul_b,
    output logic [W-1:0] mul_p,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] inv_mont
);
    seq_state_e   st;
    logic [W-1:0] acc, xr, pr;
    logic         in_mul, finish;

    assign in_mul    = (st == ST_ISSUE_MU) || (st == ST_WAIT_MU);
    assign load      = (st == ST_IDLE) && start;
    assign mul_start = (st == ST_ISSUE_SQ) || (st == ST_ISSUE_MU);
    assign mul_a     = acc;
    assign mul_b     = in_mul ? xr : acc;
    assign mul_p     = pr;
    assign busy      = (st != ST_IDLE);

    always_comb begin
        step   = 1'b0;
        finish = 1'b0;
        if (mul_done) begin
            if (st == ST_WAIT_SQ && !cur_bit) begin
                step   = !at_lsb;
                finish = at_lsb;
            end else if (st == ST_WAIT_MU) begin
                step   = !at_lsb;
                finish = at_lsb;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            acc      <= '0;
            xr       <= '0;
            pr       <= '0;
            done     <= 1'b0;
            inv_mont <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    acc <= mont_one;
                    xr  <= x_mont;
                    pr  <= modulus;
                    st  <= ST_ISSUE_SQ;
                end
                ST_ISSUE_SQ: st <= ST_WAIT_SQ;
                ST_ISSUE_MU: st <= ST_WAIT_MU;
                ST_WAIT_SQ, ST_WAIT_MU: if (mul_done) begin
                    acc <= mul_res;
                    if (st == ST_WAIT_SQ && cur_bit) st <= ST_ISSUE_MU;
                    else if (finish) begin
                        inv_mont <= mul_res;
                        done     <= 1'b1;
                        st       <= ST_IDLE;
                    end else st <= ST_ISSUE_SQ;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R8
    AST_START_TAKES: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy); // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(inv_mont)); // R6

endmodule

// File: rtl/fermat_inverter.sv
module fermat_inverter
    import inv_seq_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] x_mont,
    input  logic [W-1:0] modulus,
    input  logic [W-1:0] mont_one,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] inv_mont
);
    logic         load, step, cur_bit, at_lsb;
    logic         mul_start, mul_done;
    logic [W-1:0] mul_a, mul_b, mul_p, mul_res;

    fi_exp_scan #(.W(W)) u_scan (
        .clk(clk), .rst(rst), .load(load), .modulus(modulus),
        .step(step), .cur_bit(cur_bit), .at_lsb(at_lsb)
    );

    fi_seq_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .x_mont(x_mont),
        .modulus(modulus), .mont_one(mont_one), .mul_done(mul_done),
        .mul_res(mul_res), .cur_bit(cur_bit), .at_lsb(at_lsb),
        .load(load), .step(step), .mul_start(mul_start),
        .mul_a(mul_a), .mul_b(mul_b), .mul_p(mul_p),
        .busy(busy), .done(done), .inv_mont(inv_mont)
    );

    fi_mont_mul #(.W(W)) u_mul (
        .clk(clk), .rst(rst), .start(mul_start), .a(mul_a), .b(mul_b),
        .p(mul_p), .done(mul_done), .res(mul_res)
    );

endmodule

// File: tb/fermat_inverter_tb.sv
module fermat_inverter_tb_top;
    localparam int unsigned W      = 16;
    localparam time         CLK_P  = 10ns;
    localparam int          OP_LIM = 20000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] x_mont = '0, modulus = '0, mont_one = '0;
    logic         busy, done;
    logic [W-1:0] inv_mont;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_P/2) clk = ~clk;

    fermat_inverter #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .x_mont(x_mont),
        .modulus(modulus), .mont_one(mont_one),
        .busy(busy), .done(done), .inv_mont(inv_mont)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint modinv(input longint a, input longint m);
        longint t, nt, r, nr, q, tmp;
        t = 0; nt = 1; r = m; nr = a;
        while (nr != 0) begin
            q = r / nr;
            tmp = t - q * nt; t = nt; nt = tmp;
            tmp = r - q * nr; r = nr; nr = tmp;
        end
        if (t < 0) t = t + m;
        return t;
    endfunction

    function automatic int bitlen(input longint v);
        int n = 0;
        while (v != 0) begin n++; v = v >> 1; end
        return n;
    endfunction

    function automatic int popcnt(input longint v);
        int n = 0;
        while (v != 0) begin n += int'(v & 1); v = v >> 1; end
        return n;
    endfunction

    // Runs one inversion; interfere > 0 pulses a stray start at that cycle.
    task automatic run_inv(input longint p, input longint x, input int interfere);
        longint rr, xm, one, exp_res, got, held;
        int cyc, exp_lat;
        bit timed_out;
        rr      = (longint'(1) << W) % p;
        one     = rr;
        xm      = (x * rr) % p;
        exp_res = (modinv(x, p) * rr) % p;
        exp_lat = (bitlen(p - 2) + popcnt(p - 2)) * (W + 3);
        @(negedge clk);
        modulus = W'(p); x_mont = W'(xm); mont_one = W'(one); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8 busy after start", longint'(busy), 1);
        cyc = 0; timed_out = 0;
        forever begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            start = 1'b0;
            if (done) break;
            check(busy == 1'b1, "R8 busy during run", longint'(busy), 1);
            if (interfere > 0 && cyc == interfere) begin
                modulus = W'(7); x_mont = W'(3); mont_one = W'(1); start = 1'b1;
            end
            if (cyc > OP_LIM) begin timed_out = 1; break; end
        end
        check(!timed_out, "R4 completion within limit", cyc, exp_lat);
        got = longint'(inv_mont);
        check(got == exp_res, interfere > 0 ? "R5 result under stray start" : "R2 R3 inverse", got, exp_res);
        check(((got * modinv(rr, p)) % p) * x % p == 1, "R2 product is one", got, exp_res);
        check(cyc == exp_lat, interfere > 0 ? "R5 latency under stray start" : "R4 latency", cyc, exp_lat);
        check(busy == 1'b0, "R8 idle at done", longint'(busy), 0);
        held = got;
        @(negedge clk);
        check(done == 1'b0, "R6 done one cycle", longint'(done), 0);
        check(longint'(inv_mont) == held, "R6 result held", longint'(inv_mont), held);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        longint primes[10] = '{3, 5, 7, 13, 251, 257, 4093, 8191, 32749, 65521};
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(busy == 0, "R1 busy in reset", longint'(busy), 0);
        check(done == 0, "R1 done in reset", longint'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        check(inv_mont == '0, "R1 result after reset", longint'(inv_mont), 0);
        check(busy == 0 && done == 0, "R1 idle after reset", longint'({busy, done}), 0);

        // R7 shortest moduli
        run_inv(3, 1, 0);
        run_inv(3, 2, 0);
        run_inv(5, 2, 0);
        run_inv(5, 4, 0);
        // R2 corner operands at the largest modulus
        run_inv(65521, 1, 0);
        run_inv(65521, 65520, 0);
        run_inv(257, 256, 0);
        // R5 stray start mid-run
        run_inv(65521, 12345, 40);
        run_inv(251, 17, 5);
        // R3 random moduli and operands
        for (int i = 0; i < 20; i++) begin
            longint p, x;
            p = primes[$urandom_range(9, 0)];
            x = longint'($urandom_range(32'(p - 1), 1));
            run_inv(p, x, 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule